// File: doc/BRIEF.md
# Half-Duplex Reply Transmitter with Bus Turnaround

This block sends one reply frame onto a shared two-wire half-duplex serial bus. It owns the line-driver enable of the bus transceiver. It waits out the silent interval that must separate the incoming request from the outgoing reply, and it hands bytes to a byte-wide UART transmitter. When the last character has physically left the wire, it releases the bus and returns the link to listening.

The surrounding controller drives three things. It pulses `gap_start` when it has accepted a request addressed to this node. It later pulses `reply_ready` with the payload length, once the payload sits in a reply buffer that this block reads through a combinational read port. The turnaround timer is loaded with the required silent interval minus the receive timeout that has already passed on the line, and never less than one microsecond. If the reply is ready before that timer runs out, transmission waits for it. Otherwise transmission starts at once. The block computes the 16-bit frame check over the payload itself and appends it. The payload builder therefore never handles the checksum.

The receiver enable output stays low from the moment a request is accepted until the reply has fully drained. This keeps the node from hearing its own echo.

Top module: `rs485_reply_tx`

## Requirements
- R1: After reset, `drv_en`, `tx_wr` and `done` are low and `rx_en` is high.
- R2: The turnaround length is L = max(GAP_US - RXTO_US, 1) × CLK_PER_US cycles. For BAUD ≤ 19200, GAP_US = 38500000/BAUD and RXTO_US = 16500000/BAUD (integer division). For higher rates they are 1750 and 750. A `gap_start` pulse in cycle t keeps the turnaround running through cycle t+L.
- R3: A `reply_ready` pulse accepted in cycle r while idle raises `drv_en` in cycle max(r, t+L)+1 when a turnaround was started in cycle t ≤ r, and in cycle r+1 when none is pending. This rule also covers r = t+L, where the strobe meets the final timer cycle, and r = t. Exactly one frame results in every case.
- R4: `drv_en` is high for at least one full cycle before the first `tx_wr`.
- R5: While sending, `tx_wr` is high in exactly those cycles where `tx_empty` is high. Payload bytes are taken in address order 0 … len-1 from `rd_data` at `rd_addr` in the same cycle. A frame carries len+2 writes.
- R6: The two bytes after the payload are a CRC-16 with initial value 0xFFFF and reflected polynomial 0xA001 over the payload bytes, low byte first and then high byte. A zero-length reply therefore sends 0xFF, 0xFF.
- R7: After the last write, `drv_en` stays high until `tx_complete` is sampled high. In the next cycle `drv_en` is low and `done` is high for exactly one cycle.
- R8: `rx_en` goes low in the cycle after `gap_start` or an accepted `reply_ready`, and returns high in the cycle in which `done` is high.
- R9: A `reply_ready` pulse that arrives while a frame is waiting, being sent or draining has no effect: no byte is added and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gap_start | input | 1 | Pulse: a request addressed to this node was accepted; start the turnaround timer |
| reply_ready | input | 1 | Pulse: reply payload is in the buffer |
| reply_len | input | LEN_W | Payload length in bytes, sampled with `reply_ready` |
| rd_addr | output | LEN_W | Reply buffer read address |
| rd_data | input | 8 | Reply buffer byte at `rd_addr`, valid in the same cycle |
| tx_empty | input | 1 | UART holding register is empty |
| tx_complete | input | 1 | UART holding register and shift register are both empty |
| drv_en | output | 1 | Transceiver line-driver enable |
| tx_data | output | 8 | Byte for the UART |
| tx_wr | output | 1 | Write strobe for `tx_data` |
| done | output | 1 | One-cycle pulse: bus released |
| rx_en | output | 1 | Receiver enable |

## Verification
Two events can fall in the same cycle: the reply-ready strobe and the last cycle of the turnaround countdown. The bench places the strobe exactly L cycles after the timer start, and also one cycle later and in the same cycle as the timer start. In each case it expects a single rise of the driver enable in cycle max(r, t+L)+1 and a single correctly framed reply in the captured UART stream. A cycle-level model also checks, on every clock, that a strobe arriving mid-frame changes nothing.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WAIT  = 3'd1,
    PH_ARM   = 3'd2,
    PH_SEND  = 3'd3,
    PH_DRAIN = 3'd4
  } phase_e;

  // Silent interval required between frames, in microseconds
  function automatic int frame_gap_us(input int baud);
    return (baud <= 19200) ? (38500000 / baud) : 1750;
  endfunction

  // Receive timeout already elapsed when a request is accepted, in microseconds
  function automatic int rx_timeout_us(input int baud);
    return (baud <= 19200) ? (16500000 / baud) : 750;
  endfunction

  // One byte step of the reflected 0xA001 checksum
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rtx_gap_timer.sv
module rtx_gap_timer #(
  parameter int CNT_W    = 18,
  parameter int LOAD_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic [CNT_W-1:0] left
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CNT_W'(LOAD_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign left = cnt_q;

  AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left == CNT_W'(LOAD_CYC))); // R2

  AST_GAP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (left != '0)) |=> (left == ($past(left) - CNT_W'(1)))); // R2

endmodule

// File: rtl/rtx_crc_acc.sv
module rtx_crc_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] crc_q;
  logic [15:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr) begin
      crc_d = 16'hFFFF;
    end else if (en) begin
      crc_d = rtx_pkg::crc16_byte(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 16'hFFFF;
    end else if (clr || en) begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 16'hFFFF)); // R6

endmodule

// File: rtl/rtx_sequencer.sv
module rtx_sequencer
  import rtx_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reply_ready,
  input  logic [LEN_W-1:0] reply_len,
  input  logic             gap_start,
  input  logic [CNT_W-1:0] gap_left,
  input  logic             tx_empty,
  input  logic             tx_complete,
  input  logic [7:0]       rd_data,
  input  logic [15:0]      crc,
  output logic [LEN_W-1:0] rd_addr,
  output logic [7:0]       tx_data,
  output logic             tx_wr,
  output logic             drv_en,
  output logic             done,
  output logic             rx_en,
  output logic             crc_clr,
  output logic             crc_en
);

  localparam int IDX_W = LEN_W + 1;

  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             done_q, done_d;
  logic             rx_en_q, rx_en_d;

  logic             accept;
  logic             in_payload;
  logic             last_byte;
  logic             gap_long;

  assign accept     = (ph_q == PH_IDLE) && reply_ready;
  assign in_payload = idx_q < {1'b0, len_q};
  assign last_byte  = idx_q == ({1'b0, len_q} + IDX_W'(1));
  assign gap_long   = gap_left > CNT_W'(1);

  // Next-state logic
  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    len_d = len_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (reply_ready) begin
          len_d = reply_len;
          ph_d  = (gap_start || gap_long) ? PH_WAIT : PH_ARM;
        end
      end
      PH_WAIT: begin
        if (!gap_start && !gap_long) ph_d = PH_ARM;
      end
      PH_ARM: begin
        idx_d = '0;
        ph_d  = PH_SEND;
      end
      PH_SEND: begin
        if (tx_empty) begin
          idx_d = idx_q + IDX_W'(1);
          if (last_byte) ph_d = PH_DRAIN;
        end
      end
      PH_DRAIN: begin
        if (tx_complete) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    done_d  = (ph_q == PH_DRAIN) && tx_complete;
    rx_en_d = rx_en_q;
    if (gap_start || accept) begin
      rx_en_d = 1'b0;
    end else if (done_d) begin
      rx_en_d = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      rx_en_q <= 1'b1;
    end else begin
      ph_q    <= ph_d;
      done_q  <= done_d;
      rx_en_q <= rx_en_d;
      if ((ph_q == PH_ARM) || (ph_q == PH_SEND)) idx_q <= idx_d;
      if (accept) len_q <= len_d;
    end
  end

  // Outputs
  assign drv_en  = (ph_q == PH_ARM) || (ph_q == PH_SEND) || (ph_q == PH_DRAIN);
  assign tx_wr   = (ph_q == PH_SEND) && tx_empty;
  assign rd_addr = idx_q[LEN_W-1:0];
  assign crc_clr = (ph_q == PH_ARM);
  assign crc_en  = tx_wr && in_payload;
  assign done    = done_q;
  assign rx_en   = rx_en_q;

  always_comb begin
    if (in_payload) begin
      tx_data = rd_data;
    end else if (idx_q == {1'b0, len_q}) begin
      tx_data = crc[7:0];
    end else begin
      tx_data = crc[15:8];
    end
  end

  AST_ARM_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ARM) |-> (gap_left == '0)); // R3

  AST_DRV_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> !tx_wr); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_RELEASE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> done); // R7

  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> !rx_en); // R8

endmodule

// File: rtl/rs485_reply_tx.sv
module rs485_reply_tx #(
  parameter int BAUD       = 19200,
  parameter int CLK_PER_US = 125,
  parameter int LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gap_start,
  input  logic             reply_ready,
  input  logic [LEN_W-1:0] reply_len,
  output logic [LEN_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  input  logic             tx_empty,
  input  logic             tx_complete,
  output logic             drv_en,
  output logic [7:0]       tx_data,
  output logic             tx_wr,
  output logic             done,
  output logic             rx_en
);

  localparam int GAP_US   = rtx_pkg::frame_gap_us(BAUD);
  localparam int RXTO_US  = rtx_pkg::rx_timeout_us(BAUD);
  localparam int LOAD_US  = (GAP_US > RXTO_US) ? (GAP_US - RXTO_US) : 1;
  localparam int LOAD_CYC = LOAD_US * CLK_PER_US;
  localparam int CNT_W    = $clog2(LOAD_CYC + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0] gap_left;
  logic [15:0]      crc;
  logic             crc_clr;
  logic             crc_en;

  rtx_gap_timer #(
    .CNT_W    (CNT_W),
    .LOAD_CYC (LOAD_CYC)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (gap_start),
    .left  (gap_left)
  );

  rtx_crc_acc u_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (rd_data),
    .crc   (crc)
  );

  rtx_sequencer #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .reply_ready (reply_ready),
    .reply_len   (reply_len),
    .gap_start   (gap_start),
    .gap_left    (gap_left),
    .tx_empty    (tx_empty),
    .tx_complete (tx_complete),
    .rd_data     (rd_data),
    .crc         (crc),
    .rd_addr     (rd_addr),
    .tx_data     (tx_data),
    .tx_wr       (tx_wr),
    .drv_en      (drv_en),
    .done        (done),
    .rx_en       (rx_en),
    .crc_clr     (crc_clr),
    .crc_en      (crc_en)
  );

endmodule

// File: tb/rs485_reply_tx_bench.sv
module rs485_reply_tx_bench;

  localparam int BAUD  = 9600;
  localparam int CPU   = 1;
  localparam int LEN_W = 8;
  localparam int GAP_E = (BAUD <= 19200) ? (11 * 7 * 1000000) / (2 * BAUD) : 1750;
  localparam int TO_E  = (BAUD <= 19200) ? (11 * 3 * 1000000) / (2 * BAUD) : 750;
  localparam int L     = ((GAP_E > TO_E) ? (GAP_E - TO_E) : 1) * CPU;

  logic             clk;
  logic             rst_n;
  logic             gap_start;
  logic             reply_ready;
  logic [LEN_W-1:0] reply_len;
  logic [LEN_W-1:0] rd_addr;
  logic [7:0]       rd_data;
  logic             tx_empty;
  logic             tx_complete;
  logic             drv_en;
  logic [7:0]       tx_data;
  logic             tx_wr;
  logic             done;
  logic             rx_en;

  logic [7:0] mem [0:255];
  assign rd_data = mem[rd_addr];

  rs485_reply_tx #(.BAUD(BAUD), .CLK_PER_US(CPU), .LEN_W(LEN_W)) u_rs485_reply_tx (
    .clk(clk), .rst_n(rst_n), .gap_start(gap_start), .reply_ready(reply_ready),
    .reply_len(reply_len), .rd_addr(rd_addr), .rd_data(rd_data), .tx_empty(tx_empty),
    .tx_complete(tx_complete), .drv_en(drv_en), .tx_data(tx_data), .tx_wr(tx_wr),
    .done(done), .rx_en(rx_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) begin
      c ^= {8'h00, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  // UART transmitter model
  logic       u_full;
  int         u_shift;
  int         char_cyc = 6;
  int         us;
  bit         uf;
  logic [7:0] sent[$];

  assign tx_empty    = !u_full;
  assign tx_complete = !u_full && (u_shift == 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      u_full  <= 1'b0;
      u_shift <= 0;
    end else begin
      us = u_shift;
      uf = u_full;
      if (us > 0) us--;
      if (us == 0 && uf) begin
        us = char_cyc;
        uf = 0;
      end
      if (tx_wr) begin
        uf = 1;
        sent.push_back(tx_data);
      end
      u_shift <= us;
      u_full  <= uf;
    end
  end

  // Cycle-level reference model: 0 idle, 1 waiting, 2 arming, 3 sending, 4 draining
  int         m_ph;
  int         m_gap;
  int         m_idx;
  bit         m_done;
  bit         m_rx;
  logic [7:0] m_frame[$];
  logic [7:0] pl[$];
  logic [15:0] mc;
  bit         m_acc;
  bit         m_nd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_gap = 0; m_idx = 0; m_done = 0; m_rx = 1;
    end else begin
      m_nd  = (m_ph == 4) && tx_complete;
      m_acc = (m_ph == 0) && reply_ready;
      case (m_ph)
        0: if (reply_ready) begin
             pl.delete();
             for (int i = 0; i < int'(reply_len); i++) pl.push_back(mem[i]);
             mc = ref_crc(pl);
             m_frame = pl;
             m_frame.push_back(mc[7:0]);
             m_frame.push_back(mc[15:8]);
             m_ph = (gap_start || m_gap > 1) ? 1 : 2;
           end
        1: if (!gap_start && m_gap <= 1) m_ph = 2;
        2: begin m_idx = 0; m_ph = 3; end
        3: if (tx_empty) begin
             m_idx++;
             if (m_idx == m_frame.size()) m_ph = 4;
           end
        4: if (tx_complete) m_ph = 0;
        default: m_ph = 0;
      endcase
      if (gap_start || m_acc) m_rx = 0;
      else if (m_nd) m_rx = 1;
      if (gap_start) m_gap = L;
      else if (m_gap > 0) m_gap--;
      m_done = m_nd;
    end
  end

  // Per-cycle comparison, away from the active edge
  bit model_on = 0;
  bit drv_prev = 0;
  int rise_cyc = -1;
  int first_wr = -1;
  bit exp_wr;

  always @(negedge clk) begin
    if (model_on) begin
      exp_wr = (m_ph == 3) && tx_empty;
      chk(drv_en == (m_ph >= 2), "R3 drv_en vs model", drv_en, m_ph >= 2);
      chk(tx_wr == exp_wr, "R5 tx_wr vs model", tx_wr, exp_wr);
      if (exp_wr && m_idx < m_frame.size())
        chk(tx_data == m_frame[m_idx], "R6 tx_data vs model", tx_data, m_frame[m_idx]);
      chk(done == m_done, "R7 done vs model", done, m_done);
      chk(rx_en == m_rx, "R8 rx_en vs model", rx_en, m_rx);
      if (drv_en && !drv_prev) rise_cyc = cyc;
      if (tx_wr && first_wr < 0) first_wr = cyc;
      drv_prev = drv_en;
    end
  end

  task automatic run_frame(input int len, input bit use_gap, input int delay, input bit poke);
    int t = 0;
    int r = 0;
    int exp_rise;
    int k;
    logic [7:0] q[$];
    logic [15:0] c;
    for (int i = 0; i < len; i++) q.push_back(mem[i]);
    c = ref_crc(q);
    q.push_back(c[7:0]);
    q.push_back(c[15:8]);
    sent.delete();
    rise_cyc = -1;
    first_wr = -1;
    for (int d = 0; d <= delay; d++) begin
      @(negedge clk);
      if (d == 0) t = cyc;
      gap_start   = use_gap && (d == 0);
      reply_ready = (d == delay);
      reply_len   = LEN_W'(len);
      if (d == delay) r = cyc;
    end
    @(negedge clk);
    gap_start   = 0;
    reply_ready = 0;
    if (use_gap && delay > 0) chk(rx_en == 0, "R8 rx_en low during turnaround", rx_en, 0);
    k = 0;
    while (!done && k < 40000) begin
      @(negedge clk);
      k++;
      if (poke && rise_cyc >= 0 && cyc == rise_cyc + 3) reply_ready = 1;
      else reply_ready = 0;
    end
    reply_ready = 0;
    exp_rise = use_gap ? (((r > t + L) ? r : t + L) + 1) : r + 1;
    chk(rise_cyc == exp_rise, "R2/R3 driver rise cycle", rise_cyc, exp_rise);
    chk(first_wr > rise_cyc, "R4 first write after driver on", first_wr, rise_cyc + 1);
    chk(drv_en == 0 && rx_en == 1, "R7 released at done", {drv_en, rx_en}, 2'b01);
    chk(sent.size() == len + 2, "R5 byte count", sent.size(), len + 2);
    for (int i = 0; i < len + 2 && i < sent.size(); i++)
      chk(sent[i] == q[i], (i < len) ? "R5 payload byte" : "R6 check byte", sent[i], q[i]);
    repeat (20) @(negedge clk);
    chk(sent.size() == len + 2 && !drv_en, "R9 no extra frame", sent.size(), len + 2);
  endtask

  initial begin
    rst_n = 0; gap_start = 0; reply_ready = 0; reply_len = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(drv_en == 0 && tx_wr == 0 && done == 0 && rx_en == 1, "R1 reset state",
        {drv_en, tx_wr, done, rx_en}, 4'b0001);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(drv_en == 0 && rx_en == 1, "R1 after release", {drv_en, rx_en}, 2'b01);
    model_on = 1;

    // Known vector: 01 03 00 00 00 01 -> check bytes 84 0A
    mem[0] = 8'h01; mem[1] = 8'h03; mem[2] = 8'h00;
    mem[3] = 8'h00; mem[4] = 8'h00; mem[5] = 8'h01;
    run_frame(6, 1, 100, 0);
    chk(sent.size() == 8 && sent[6] == 8'h84 && sent[7] == 8'h0A, "R6 known vector",
        {sent[6], sent[7]}, 16'h840A);

    // Strobe in the final timer cycle, one after it, and with the timer start
    run_frame(4, 1, L, 0);
    run_frame(3, 1, L + 1, 0);
    run_frame(5, 1, 0, 0);

    // No turnaround pending; empty payload sends FF FF
    run_frame(0, 0, 0, 0);
    chk(sent.size() == 2 && sent[0] == 8'hFF && sent[1] == 8'hFF, "R6 empty payload",
        {sent[0], sent[1]}, 16'hFFFF);

    // Strobe while sending is ignored
    char_cyc = 1;
    for (int i = 0; i < 8; i++) mem[i] = 8'(8'hA0 + i);
    run_frame(8, 0, 2, 1);

    // Slow character time
    char_cyc = 20;
    run_frame(3, 1, 50, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule